// File: doc/BRIEF.md
# Wait-Balancing Flash Dispatch Selector

This block sits in front of a flash channel controller and decides which transaction the controller takes next. There are four sources: the user read slot, the user write slot, and two garbage-collection queues, one for reads and one for writes. Each slot occupant carries the timestamp at which it arrived. The block compares how long each user transaction has waited relative to its expected service time. The transaction that has fallen further behind by that measure goes first.

Reads have a much shorter service time than writes, so a read is normally chosen. A write is only chosen once it has waited many times longer than the read. When a write wins and garbage collection is pending, the block first issues a burst of GC operations before the write. The size of that burst comes from an external budget input. GC work is never issued unless a write is waiting in its slot.

Each item leaves through a valid/ready handshake, one item per accepted transfer. The upstream logic removes the item whose kind matches the accepted transfer. The upstream logic holds slot contents and queue flags steady until then.

Top module: `wait_bal_dispatch`

## Requirements
- R1: After reset, with no source valid, `disp_valid` is low.
- R2: With only the read slot valid, the read is offered (`disp_kind` 2'b00, read slot tag), even if GC work is pending.
- R3: With only the write slot valid and no GC pending, the write is offered (`disp_kind` 2'b01, write slot tag).
- R4: With both slots valid, the read is offered when (now - read stamp) x WR_SVC exceeds (now - write stamp) x RD_SVC.
- R5: With both slots valid and the write's scaled wait larger, the write is offered when no GC is pending.
- R6: When both scaled waits are equal, the read is offered.
- R7: When the write path wins, GC is pending and the budget B is non-zero, up to B GC items go out before the write. GC reads (kind 2'b10, GC read tag) go before GC writes (kind 2'b11, GC write tag). After the B-th GC item the write follows, even if GC work remains.
- R8: A budget of zero sends the write directly, whatever the GC flags say.
- R9: Once a GC burst has started, no read is offered until the burst's write has been accepted, even if the read's scaled wait becomes larger.
- R10: If both GC queues empty before the budget is used up, the write is offered next.
- R11: While `disp_valid` is high and `disp_ready` is low, `disp_kind` and `disp_tag` stay unchanged as time advances.
- R12: No GC item is offered unless the write slot is valid.
- R13: Waits are taken modulo 2^TS_W, so a timestamp from before a counter wrap yields the correct wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_ts | input | TS_W | Current time |
| rd_valid | input | 1 | Read slot occupied |
| rd_tag | input | TAG_W | Read slot transaction tag |
| rd_stamp | input | TS_W | Read slot arrival time |
| wr_valid | input | 1 | Write slot occupied |
| wr_tag | input | TAG_W | Write slot transaction tag |
| wr_stamp | input | TS_W | Write slot arrival time |
| gc_rd_pend | input | 1 | GC read queue not empty |
| gc_rd_tag | input | TAG_W | Head of GC read queue |
| gc_wr_pend | input | 1 | GC write queue not empty |
| gc_wr_tag | input | TAG_W | Head of GC write queue |
| gc_budget | input | BUD_W | GC items allowed ahead of a write |
| disp_valid | output | 1 | An item is offered |
| disp_ready | input | 1 | Controller accepts the item |
| disp_kind | output | 2 | 00 user read, 01 user write, 10 GC read, 11 GC write |
| disp_tag | output | TAG_W | Tag of the offered item |

## Verification
A wrong comparison in the scaled-wait logic shows up at once, in the same cycle, as the wrong `disp_kind` for a given pair of stamps. A burst counter that is off by one shows up after the budgeted number of accepted transfers. In that case one GC item too many or too few appears before the write. A stuck burst flag blocks reads indefinitely. A lost stall lock lets `disp_kind` flip one cycle after `now_ts` moves with `disp_ready` low.

// File: rtl/wbd_pkg.sv
package wbd_pkg;
   typedef enum logic [1:0] {
      K_USR_RD = 2'b00,
      K_USR_WR = 2'b01,
      K_GC_RD  = 2'b10,
      K_GC_WR  = 2'b11
   } disp_kind_e;
endpackage

// File: rtl/pwait_cmp.sv
// Decides whether the read's wait, scaled by its service time, is at least the write's.
module pwait_cmp #(
   parameter int TS_W   = 16,
   parameter int RD_SVC = 3,
   parameter int WR_SVC = 24
) (
   input  logic [TS_W-1:0] now_ts,
   input  logic [TS_W-1:0] rd_stamp,
   input  logic [TS_W-1:0] wr_stamp,
   output logic            read_wins
);
   localparam int MW = TS_W + $clog2(WR_SVC + 1);

   logic [TS_W-1:0] wait_r, wait_w;
   logic [MW-1:0]   lhs, rhs;

   // modular difference keeps waits right across a counter wrap (R13)
   assign wait_r = now_ts - rd_stamp;
   assign wait_w = now_ts - wr_stamp;

   generate
      if (WR_SVC % RD_SVC == 0) begin : g_ratio
         localparam int K = WR_SVC / RD_SVC;
         assign lhs = MW'(wait_r) * MW'(K);
         assign rhs = MW'(wait_w);
      end else begin : g_cross
         assign lhs = MW'(wait_r) * MW'(WR_SVC);
         assign rhs = MW'(wait_w) * MW'(RD_SVC);
      end
   endgenerate

   // ties favour the read (R6)
   assign read_wins = (lhs >= rhs);
endmodule

// File: rtl/gc_burst_ctrl.sv
// Tracks a GC burst that runs ahead of a write and counts the items issued.
module gc_burst_ctrl #(
   parameter int BUD_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [BUD_W-1:0] budget,
   input  logic             gc_fire,
   input  logic             done,
   output logic             active,
   output logic             spent
);
   logic [BUD_W-1:0] issued_q, bud_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= 1'b0;
         issued_q <= '0;
         bud_q    <= '0;
      end else if (start) begin
         active   <= 1'b1;
         issued_q <= BUD_W'(1);
         bud_q    <= budget;
      end else if (active) begin
         if (done)
            active <= 1'b0;
         else if (gc_fire)
            issued_q <= issued_q + BUD_W'(1);
      end
   end

   assign spent = (issued_q >= bud_q);

   // R7: a burst never issues more than its budget
   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (issued_q <= bud_q));

   // R7: a GC accepted during a burst is only possible while budget remains
   a_r7_gc_within_budget: assert property (@(posedge clk) disable iff (!rst_n)
      (active && gc_fire && !done) |=> (issued_q <= bud_q));
endmodule

// File: rtl/wait_bal_dispatch.sv
module wait_bal_dispatch #(
   parameter int TS_W   = 16,
   parameter int TAG_W  = 8,
   parameter int BUD_W  = 4,
   parameter int RD_SVC = 3,
   parameter int WR_SVC = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  now_ts,
   input  logic             rd_valid,
   input  logic [TAG_W-1:0] rd_tag,
   input  logic [TS_W-1:0]  rd_stamp,
   input  logic             wr_valid,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [TS_W-1:0]  wr_stamp,
   input  logic             gc_rd_pend,
   input  logic [TAG_W-1:0] gc_rd_tag,
   input  logic             gc_wr_pend,
   input  logic [TAG_W-1:0] gc_wr_tag,
   input  logic [BUD_W-1:0] gc_budget,
   output logic             disp_valid,
   input  logic             disp_ready,
   output logic [1:0]       disp_kind,
   output logic [TAG_W-1:0] disp_tag
);
   import wbd_pkg::*;

   generate
      if (RD_SVC < 1 || WR_SVC <= RD_SVC) begin : g_bad_svc
         $error("service times must satisfy 0 < RD_SVC < WR_SVC");
      end
      if (TS_W < 2 || TAG_W < 1 || BUD_W < 1) begin : g_bad_width
         $error("widths too small");
      end
   endgenerate

   logic       read_wins, gc_any, fire;
   logic       burst_act, spent, start, gc_fire, done;
   logic       lock_q;
   disp_kind_e lock_kind_q, pick, gc_kind;
   logic       pick_v;

   pwait_cmp #(.TS_W(TS_W), .RD_SVC(RD_SVC), .WR_SVC(WR_SVC)) u_cmp (
      .now_ts   (now_ts),
      .rd_stamp (rd_stamp),
      .wr_stamp (wr_stamp),
      .read_wins(read_wins)
   );

   assign gc_any  = gc_rd_pend | gc_wr_pend;
   assign gc_kind = gc_rd_pend ? K_GC_RD : K_GC_WR;

   always_comb begin
      pick_v = 1'b0;
      pick   = K_USR_RD;
      if (lock_q) begin
         pick_v = 1'b1;
         pick   = lock_kind_q;
      end else if (burst_act) begin
         if (!spent && gc_any) begin
            pick_v = 1'b1;
            pick   = gc_kind;
         end else if (wr_valid) begin
            pick_v = 1'b1;
            pick   = K_USR_WR;
         end
      end else if (rd_valid && (!wr_valid || read_wins)) begin
         pick_v = 1'b1;
         pick   = K_USR_RD;
      end else if (wr_valid) begin
         pick_v = 1'b1;
         pick   = (gc_budget != '0 && gc_any) ? gc_kind : K_USR_WR;
      end
   end

   assign disp_valid = pick_v;
   assign disp_kind  = pick;
   always_comb begin
      unique case (pick)
         K_USR_RD: disp_tag = rd_tag;
         K_USR_WR: disp_tag = wr_tag;
         K_GC_RD:  disp_tag = gc_rd_tag;
         default:  disp_tag = gc_wr_tag;
      endcase
   end

   assign fire    = pick_v && disp_ready;
   assign gc_fire = fire && pick[1];
   assign start   = gc_fire && !burst_act;
   assign done    = burst_act && ((fire && pick == K_USR_WR) || !pick_v);

   gc_burst_ctrl #(.BUD_W(BUD_W)) u_burst (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .budget (gc_budget),
      .gc_fire(gc_fire),
      .done   (done),
      .active (burst_act),
      .spent  (spent)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q      <= 1'b0;
         lock_kind_q <= K_USR_RD;
      end else begin
         lock_q      <= pick_v && !disp_ready;
         lock_kind_q <= pick;
      end
   end

   // R11: a stalled offer keeps its kind
   a_r11_hold_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_kind)));

   // R9: a running burst never lets a read through
   a_r9_no_read_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      burst_act |-> !(disp_valid && disp_kind == K_USR_RD));

   // R12: a fresh GC offer needs a waiting write
   a_r12_gc_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_kind[1] && !burst_act && !lock_q) |-> wr_valid);

   // R2: a lone read is always offered outside a burst
   a_r2_lone_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_q && !burst_act && rd_valid && !wr_valid)
         |-> (disp_valid && disp_kind == K_USR_RD));

   // R7: an accepted GC outside a burst opens one
   a_r7_burst_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ready && disp_kind[1] && !burst_act) |=> burst_act);
endmodule

// File: tb/wait_bal_dispatch_test.sv
`timescale 1ns/1ps
module wait_bal_dispatch_test;
   localparam int TS_W = 16, TAG_W = 8, BUD_W = 4, RD_SVC = 3, WR_SVC = 24;
   localparam logic [1:0] KR = 2'b00, KW = 2'b01, KGR = 2'b10, KGW = 2'b11;
   localparam logic [7:0] GRT = 8'hA0, GWT = 8'hB0;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [TS_W-1:0]  now_ts = '0;
   logic             rd_valid = 1'b0, wr_valid = 1'b0;
   logic [TAG_W-1:0] rd_tag = '0, wr_tag = '0;
   logic [TS_W-1:0]  rd_stamp = '0, wr_stamp = '0;
   logic             gc_rd_pend = 1'b0, gc_wr_pend = 1'b0;
   logic [BUD_W-1:0] gc_budget = '0;
   logic             disp_ready = 1'b1;
   logic             disp_valid;
   logic [1:0]       disp_kind;
   logic [TAG_W-1:0] disp_tag;

   int checks = 0, fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   wait_bal_dispatch #(.TS_W(TS_W), .TAG_W(TAG_W), .BUD_W(BUD_W),
                       .RD_SVC(RD_SVC), .WR_SVC(WR_SVC)) uut (
      .clk(clk), .rst_n(rst_n), .now_ts(now_ts),
      .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_stamp(rd_stamp),
      .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_stamp(wr_stamp),
      .gc_rd_pend(gc_rd_pend), .gc_rd_tag(GRT),
      .gc_wr_pend(gc_wr_pend), .gc_wr_tag(GWT),
      .gc_budget(gc_budget), .disp_valid(disp_valid),
      .disp_ready(disp_ready), .disp_kind(disp_kind), .disp_tag(disp_tag)
   );

   task automatic expect_out(string req, logic ev, logic [1:0] ek, logic [7:0] et);
      logic [10:0] act, exp;
      act = {disp_valid, disp_valid ? disp_kind : 2'b00, disp_valid ? disp_tag : 8'h00};
      exp = {ev, ev ? ek : 2'b00, ev ? et : 8'h00};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: valid/kind/tag actual %b/%b/%h expected %b/%b/%h",
                  req, act[10], act[9:8], act[7:0], exp[10], exp[9:8], exp[7:0]);
      end
   endtask

   task automatic clear_all();
      rd_valid = 0; wr_valid = 0; gc_rd_pend = 0; gc_wr_pend = 0;
      gc_budget = '0; disp_ready = 1;
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   // both slots offered; check the choice without letting it be accepted
   task automatic pair_case(string req, int now, int rw, int ww, logic [1:0] ek, logic [7:0] et);
      @(negedge clk);
      clear_all();
      now_ts = TS_W'(now);
      rd_valid = 1; rd_tag = 8'h11; rd_stamp = TS_W'(now - rw);
      wr_valid = 1; wr_tag = 8'h12; wr_stamp = TS_W'(now - ww);
      #1 expect_out(req, 1, ek, et);
      clear_all();
   endtask

   task automatic t_reset();
      @(negedge clk);
      expect_out("R1 idle after reset", 0, KR, 8'h00);
   endtask

   task automatic t_singles();
      @(negedge clk);
      clear_all(); now_ts = 16'd500;
      rd_valid = 1; rd_tag = 8'h05; rd_stamp = 16'd490;
      gc_rd_pend = 1; gc_budget = 4'd3;
      #1 expect_out("R2 lone read with GC pending", 1, KR, 8'h05);
      tick(); clear_all();
      gc_rd_pend = 1; gc_wr_pend = 1; gc_budget = 4'd3;
      #1 expect_out("R12 GC alone not offered", 0, KR, 8'h00);
      clear_all();
      wr_valid = 1; wr_tag = 8'h06; wr_stamp = 16'd499;
      #1 expect_out("R3 lone write", 1, KW, 8'h06);
      tick(); clear_all();
   endtask

   task automatic t_compare();
      pair_case("R4 read scaled wait larger", 1000, 10, 50, KR, 8'h11);
      pair_case("R5 write scaled wait larger", 1000, 2, 100, KW, 8'h12);
      pair_case("R6 equal scaled waits", 1000, 5, 40, KR, 8'h11);
      pair_case("R13 wrap write wins", 5, 4, 40, KW, 8'h12);
      pair_case("R13 wrap read wins", 3, 10, 20, KR, 8'h11);
   endtask

   task automatic t_burst();
      @(negedge clk);
      clear_all(); now_ts = 16'd2000;
      wr_valid = 1; wr_tag = 8'h21; wr_stamp = 16'd1995;
      gc_rd_pend = 1; gc_wr_pend = 1; gc_budget = 4'd3;
      #1 expect_out("R7 first GC read", 1, KGR, GRT);
      tick(); #1 expect_out("R7 second GC read", 1, KGR, GRT);
      tick(); gc_rd_pend = 0;
      #1 expect_out("R7 GC write after reads", 1, KGW, GWT);
      tick(); #1 expect_out("R7 write after budget", 1, KW, 8'h21);
      tick(); wr_valid = 0;
      #1 expect_out("R12 no GC once write gone", 0, KR, 8'h00);
      clear_all();
   endtask

   task automatic t_no_interrupt();
      @(negedge clk);
      clear_all(); now_ts = 16'd3000;
      wr_valid = 1; wr_tag = 8'h31; wr_stamp = 16'd2980;
      gc_rd_pend = 1; gc_budget = 4'd2;
      #1 expect_out("R9 burst begins", 1, KGR, GRT);
      tick();
      rd_valid = 1; rd_tag = 8'h32; rd_stamp = 16'd2900;
      #1 expect_out("R9 read held off in burst", 1, KGR, GRT);
      tick(); #1 expect_out("R9 write ends burst", 1, KW, 8'h31);
      tick(); wr_valid = 0;
      #1 expect_out("R9 read after burst", 1, KR, 8'h32);
      tick(); clear_all();
   endtask

   task automatic t_early_end();
      @(negedge clk);
      clear_all(); now_ts = 16'd4000;
      wr_valid = 1; wr_tag = 8'h41; wr_stamp = 16'd3990;
      gc_wr_pend = 1; gc_budget = 4'd5;
      #1 expect_out("R10 single GC write", 1, KGW, GWT);
      tick(); gc_wr_pend = 0;
      #1 expect_out("R10 write when GC empties", 1, KW, 8'h41);
      tick(); clear_all();
   endtask

   task automatic t_zero_budget();
      @(negedge clk);
      clear_all(); now_ts = 16'd5000;
      wr_valid = 1; wr_tag = 8'h61; wr_stamp = 16'd4990;
      gc_rd_pend = 1; gc_wr_pend = 1; gc_budget = 4'd0;
      #1 expect_out("R8 zero budget skips GC", 1, KW, 8'h61);
      tick(); wr_valid = 0;
      #1 expect_out("R8 nothing left", 0, KR, 8'h00);
      clear_all();
   endtask

   task automatic t_stall();
      @(negedge clk);
      clear_all(); now_ts = 16'd6000; disp_ready = 0;
      rd_valid = 1; rd_tag = 8'h51; rd_stamp = 16'd5999;
      wr_valid = 1; wr_tag = 8'h52; wr_stamp = 16'd5980;
      #1 expect_out("R11 write offered", 1, KW, 8'h52);
      for (int i = 0; i < 3; i++) begin
         tick(); now_ts = now_ts + 16'd10;
         #1 expect_out("R11 held while stalled", 1, KW, 8'h52);
      end
      disp_ready = 1;
      #1 expect_out("R11 held at accept", 1, KW, 8'h52);
      tick(); wr_valid = 0;
      #1 expect_out("R11 read follows", 1, KR, 8'h51);
      tick(); clear_all();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_singles();
      t_compare();
      t_burst();
      t_no_interrupt();
      t_early_end();
      t_zero_budget();
      t_stall();
      repeat (2) @(posedge clk);
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule